// File: doc/BRIEF.md
# Serial Control Register File for a Multi-Output Clock Generator

This block is the two-wire serial slave that holds the control state of a multi-output clock generator. A fast system clock oversamples the bus clock and data lines, and the block pulls the data line low as an open-drain device. After a matching address byte, the first two bytes of every transfer are a command placeholder and a count placeholder. Both are acknowledged and then discarded. Every byte after them walks through the register file in order, starting at index 0, for both writes and reads.

The register contents drive the rest of the clock generator directly. The outputs are a 6-bit frequency-select code, a global tristate request, the spread-spectrum controls, and one enable bit per clock output. The frequency-select code is taken either from five strap pins or from software bits. The strap levels are captured once after the power-up reset, and software can read them back in fixed bit positions. Two further registers return constant identification bytes. The power-down input stops the bus engine but never reloads the registers.

The protocol engine has five named states:
- IDLE: waits for a START.
- RX_BYTE: shifts in eight bits on SCL rising edges.
- RX_ACK: holds SDA low during the ninth clock.
- TX_BYTE: drives eight bits, changing SDA after each SCL falling edge.
- TX_ACK: samples the master's acknowledge.

Its transitions are:
- Any state goes to RX_BYTE on START.
- Any state goes to IDLE on STOP or power-down.
- RX_BYTE goes to RX_ACK after eight bits, except when the address does not match; then it goes to IDLE.
- RX_ACK goes to TX_BYTE after a read address, and to RX_BYTE otherwise.
- TX_BYTE goes to TX_ACK after eight bits.
- TX_ACK goes to TX_BYTE on an acknowledge, and to IDLE on a not-acknowledge.

A byte phase tracks progress through ADDR, CMD, CNT and DATA.

Top module: `clkgen_i2c_regfile`

## Requirements
- R1: The block acknowledges an address byte whose bits 7:1 equal the parameter ADDR by holding SDA low in the ninth clock; bit 0 is 1 for read and 0 for write. A mismatching address gets no acknowledge, and later bytes are neither acknowledged nor written until the next START.
- R2: The two bytes that follow a write address are acknowledged and change no register.
- R3: Every later write byte is acknowledged and stored to index 0, then 1, 2 and so on.
- R4: freq_code_o is {1'b0, strap_fs_i[4:0] as latched} while register 0 bit 3 is 0. While that bit is 1, the code is {reg0[1], reg0[2], reg0[7:4]}.
- R5: tristate_o equals register 0 bit 0.
- R6: In register 1, bit 0 is spread_en_o and bit 1 is spread_quarter_o (1 = 0.25 %, 0 = 0.5 %). Register 1 bits 4:2 drive aux_en_o[2:0]. Register 2 is sdram_en_o, and register 3 is pci_en_o. In register 4, bits 6:5 are hub_en_o[1:0], bit 3 is irqclk_en_o and bits 1:0 are cpu_en_o[1:0].
- R7: Strap levels are captured on the first clock after reset and then held. Readback places them at register 1 bits 7/6/5 = FS3/FS0/FS2 and register 4 bits 7/4/2 = APIC/FS4/FS1. These bits cannot be written.
- R8: After the power-up reset the register values are: register 0 = 0x00, register 1 writable bits 4:0 = 11110, registers 2 and 3 = 0xFF, register 4 bits 6, 5, 3, 1 and 0 = 1, register 5 = 0x90.
- R9: Registers 6 and 7 read 0x98 and 0x21. Writes to index 6 and above are acknowledged without effect, and reads at index 8 and above return 0x00.
- R10: A read transfer returns 0x00 and 0x00, then register 0, register 1 and onward. A master not-acknowledge ends the transfer.
- R11: A START or STOP in the middle of a byte aborts the transfer. The next transfer writes from index 0 again.
- R12: While pdn_i is 1 the engine stays idle and acknowledges nothing. Register contents survive a power-down.
- R13: sda_low_o is 1 only in an acknowledge slot or while read data is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low power-up reset; loads the register defaults |
| pdn_i | input | 1 | Power-down; halts the bus engine |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line as seen on the wire |
| sda_low_o | output | 1 | Pull the data line low (open-drain) |
| strap_fs_i | input | 5 | Frequency strap pin levels, bit n = FSn |
| strap_apic_i | input | 1 | Interrupt-clock divider strap level |
| freq_code_o | output | 6 | Effective frequency-select code |
| tristate_o | output | 1 | Place all clock outputs in tristate |
| spread_en_o | output | 1 | Spread-spectrum enable |
| spread_quarter_o | output | 1 | Spread amount: 1 = 0.25 %, 0 = 0.5 % |
| aux_en_o | output | 3 | Enables for the 24/48 MHz and the two 48 MHz outputs |
| sdram_en_o | output | 8 | Memory clock enables |
| pci_en_o | output | 8 | Peripheral bus clock enables |
| hub_en_o | output | 2 | 66 MHz-class hub clock enables |
| irqclk_en_o | output | 1 | Interrupt-controller clock enable |
| cpu_en_o | output | 2 | Processor clock enables |

## Verification
The assertions check the following on every cycle:
- the data line is pulled low only in the acknowledge and transmit states;
- a START or power-down forces the idle or byte-receive state with a cleared pointer;
- each write strobe lasts a single cycle;
- writes to the read-only indices leave the storage untouched;
- the latched straps and the effective code stay put when nothing is written.

Only the bench's scenarios can show the rest, because it depends on full bus transfers:
- the placement of every field;
- the discarded placeholder bytes;
- the readback order with its two leading zero bytes;
- the strap echo after the strap pins change;
- recovery from a START that interrupts a byte.

// File: rtl/clkgen_regs_pkg.sv
package clkgen_regs_pkg;

    localparam int BYTE_W  = 8;
    localparam int NSTORE  = 6;   // indices 0..5 hold writable storage
    localparam int NREGS   = 8;   // indices 6 and 7 are constants
    localparam int FS_W    = 5;
    localparam int CODE_W  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_BYTE,
        ST_RX_ACK,
        ST_TX_BYTE,
        ST_TX_ACK
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } bus_phase_e;

    function automatic bus_phase_e phase_after(bus_phase_e p);
        case (p)
            PH_ADDR: return PH_CMD;
            PH_CMD:  return PH_CNT;
            default: return PH_DATA;
        endcase
    endfunction

    // Bits software may change, per storage index
    function automatic logic [BYTE_W-1:0] reg_wmask(int idx);
        case (idx)
            1:       return 8'h1F;
            4:       return 8'h6B;
            default: return 8'hFF;
        endcase
    endfunction

    // Power-up contents of the writable bits
    function automatic logic [BYTE_W-1:0] reg_default(int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h1E;
            2, 3:    return 8'hFF;
            4:       return 8'h6B;
            5:       return 8'h90;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cgr_line_sync.sv
module cgr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int CH_W = STAGES + 1;   // synchronizer stages plus one history flop

    logic [CH_W-1:0] scl_ch, sda_ch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ch <= '1;
            sda_ch <= '1;
        end else begin
            scl_ch <= {scl_ch[CH_W-2:0], scl_i};
            sda_ch <= {sda_ch[CH_W-2:0], sda_i};
        end
    end

    // [CH_W-2] is the synchronized value, [CH_W-1] the previous one
    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_ch[CH_W-2];
    assign scl_old = scl_ch[CH_W-1];
    assign sda_now = sda_ch[CH_W-2];
    assign sda_old = sda_ch[CH_W-1];

    assign sda_s_o    = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/cgr_bus_engine.sv
module cgr_bus_engine
    import clkgen_regs_pkg::*;
#(
    parameter logic [6:0] ADDR  = 7'h69,
    parameter int         PTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_i,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              sda_low_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [PTR_W-1:0]  rd_idx_o,
    input  logic [BYTE_W-1:0] rd_data_i
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    bus_state_e         state_q, state_d;
    bus_phase_e         phase_q, phase_nx;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic [PTR_W-1:0]   ptr_q, ptr_nx;
    logic [BYTE_W-1:0]  rx_q, tx_q, tx_next;
    logic               sda_low_q, wr_en_q;
    logic [PTR_W-1:0]   wr_idx_q;
    logic [BYTE_W-1:0]  wr_data_q;

    logic addr_hit, rx_done, rx_ack_ok, rx_ack_end, tx_bit_end, tx_ack_end, go_tx;

    assign addr_hit = (rx_q[BYTE_W-1:1] == ADDR);
    assign phase_nx = phase_after(phase_q);
    assign ptr_nx   = (phase_q != PH_DATA) ? ptr_q :
                      ((ptr_q == '1) ? ptr_q : ptr_q + 1'b1);
    assign rd_idx_o = ptr_nx;
    assign tx_next  = (phase_nx == PH_DATA) ? rd_data_i : '0;
    assign go_tx    = (phase_q == PH_ADDR) && rx_q[0];

    // Next-state logic and byte events
    always_comb begin
        state_d    = state_q;
        rx_done    = 1'b0;
        rx_ack_ok  = 1'b0;
        rx_ack_end = 1'b0;
        tx_bit_end = 1'b0;
        tx_ack_end = 1'b0;
        if (pdn_i || stop_i) begin
            state_d = ST_IDLE;
        end else if (start_i) begin
            state_d = ST_RX_BYTE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RX_BYTE: begin
                    if (scl_fall_i && bit_cnt_q == FULL_CNT) begin
                        rx_done = 1'b1;
                        if (phase_q != PH_ADDR || addr_hit) begin
                            rx_ack_ok = 1'b1;
                            state_d   = ST_RX_ACK;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall_i) begin
                        rx_ack_end = 1'b1;
                        state_d    = go_tx ? ST_TX_BYTE : ST_RX_BYTE;
                    end
                end
                ST_TX_BYTE: begin
                    if (scl_fall_i) begin
                        tx_bit_end = 1'b1;
                        if (bit_cnt_q == LAST_BIT) state_d = ST_TX_ACK;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise_i && sda_s_i) begin
                        state_d = ST_IDLE;
                    end else if (scl_fall_i) begin
                        tx_ack_end = 1'b1;
                        state_d    = ST_TX_BYTE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and line outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= PH_ADDR;
            bit_cnt_q <= '0;
            ptr_q     <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            sda_low_q <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_idx_q  <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (pdn_i || stop_i) begin
                sda_low_q <= 1'b0;
            end else if (start_i) begin
                phase_q   <= PH_ADDR;
                bit_cnt_q <= '0;
                ptr_q     <= '0;
                sda_low_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_RX_BYTE: begin
                        if (scl_rise_i && bit_cnt_q != FULL_CNT) begin
                            rx_q      <= {rx_q[BYTE_W-2:0], sda_s_i};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (rx_ack_ok) begin
                            sda_low_q <= 1'b1;
                            if (phase_q == PH_DATA) begin
                                wr_en_q   <= 1'b1;
                                wr_idx_q  <= ptr_q;
                                wr_data_q <= rx_q;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (rx_ack_end) begin
                            bit_cnt_q <= '0;
                            phase_q   <= phase_nx;
                            ptr_q     <= ptr_nx;
                            if (go_tx) begin
                                tx_q      <= tx_next;
                                sda_low_q <= ~tx_next[BYTE_W-1];
                            end else begin
                                sda_low_q <= 1'b0;
                            end
                        end
                    end
                    ST_TX_BYTE: begin
                        if (tx_bit_end) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            if (bit_cnt_q == LAST_BIT) begin
                                sda_low_q <= 1'b0;
                            end else begin
                                tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                                sda_low_q <= ~tx_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (tx_ack_end) begin
                            bit_cnt_q <= '0;
                            phase_q   <= phase_nx;
                            ptr_q     <= ptr_nx;
                            tx_q      <= tx_next;
                            sda_low_q <= ~tx_next[BYTE_W-1];
                        end
                    end
                    default: sda_low_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_low_o = sda_low_q;
    assign wr_en_o   = wr_en_q;
    assign wr_idx_o  = wr_idx_q;
    assign wr_data_o = wr_data_q;

    // R13: the line is pulled only in acknowledge or transmit slots
    a_r13_sda_only_ack_or_tx: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low_q |-> (state_q == ST_RX_ACK || state_q == ST_TX_BYTE));

    // R11: a START restarts the byte and the register pointer
    a_r11_start_clears_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !pdn_i && !stop_i) |=> (state_q == ST_RX_BYTE && ptr_q == '0 && bit_cnt_q == '0));

    // R12: power-down holds the engine idle with the line released
    a_r12_pdn_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_i |=> (state_q == ST_IDLE && !sda_low_q));

    // R3: one register write strobe per received byte
    a_r3_write_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |=> !wr_en_q);

endmodule

// File: rtl/cgr_reg_bank.sv
module cgr_reg_bank
    import clkgen_regs_pkg::*;
#(
    parameter int               PTR_W = 4,
    parameter logic [BYTE_W-1:0] ID_HI = 8'h98,
    parameter logic [BYTE_W-1:0] ID_LO = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic [FS_W-1:0]   strap_fs_i,
    input  logic              strap_apic_i,
    output logic [CODE_W-1:0] freq_code_o,
    output logic              tristate_o,
    output logic              spread_en_o,
    output logic              spread_quarter_o,
    output logic [2:0]        aux_en_o,
    output logic [7:0]        sdram_en_o,
    output logic [7:0]        pci_en_o,
    output logic [1:0]        hub_en_o,
    output logic              irqclk_en_o,
    output logic [1:0]        cpu_en_o
);
    logic [NSTORE-1:0][BYTE_W-1:0] store_q;
    logic [FS_W-1:0] fs_q;
    logic            apic_q, cap_done_q;

    // One-time strap capture after power-up reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q       <= '0;
            apic_q     <= 1'b0;
            cap_done_q <= 1'b0;
        end else if (!cap_done_q) begin
            fs_q       <= strap_fs_i;
            apic_q     <= strap_apic_i;
            cap_done_q <= 1'b1;
        end
    end

    // Writable storage, one masked byte per index
    for (genvar gi = 0; gi < NSTORE; gi++) begin : g_store
        localparam logic [BYTE_W-1:0] WMASK = reg_wmask(gi);
        localparam logic [BYTE_W-1:0] RVAL  = reg_default(gi);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store_q[gi] <= RVAL;
            end else if (wr_en_i && wr_idx_i == PTR_W'(gi)) begin
                store_q[gi] <= (store_q[gi] & ~WMASK) | (wr_data_i & WMASK);
            end
        end
    end

    // Readback with strap echoes merged in
    logic [BYTE_W-1:0] echo1, echo4;
    assign echo1 = {fs_q[3], fs_q[0], fs_q[2], 5'b0};
    assign echo4 = {apic_q, 2'b0, fs_q[4], 1'b0, fs_q[1], 2'b0};

    always_comb begin
        case (rd_idx_i)
            PTR_W'(0): rd_data_o = store_q[0];
            PTR_W'(1): rd_data_o = store_q[1] | echo1;
            PTR_W'(2): rd_data_o = store_q[2];
            PTR_W'(3): rd_data_o = store_q[3];
            PTR_W'(4): rd_data_o = store_q[4] | echo4;
            PTR_W'(5): rd_data_o = store_q[5];
            PTR_W'(6): rd_data_o = ID_HI;
            PTR_W'(7): rd_data_o = ID_LO;
            default:   rd_data_o = '0;
        endcase
    end

    // Control outputs
    assign freq_code_o      = store_q[0][3] ?
                              {store_q[0][1], store_q[0][2], store_q[0][7:4]} :
                              {1'b0, fs_q};
    assign tristate_o       = store_q[0][0];
    assign spread_en_o      = store_q[1][0];
    assign spread_quarter_o = store_q[1][1];
    assign aux_en_o         = store_q[1][4:2];
    assign sdram_en_o       = store_q[2];
    assign pci_en_o         = store_q[3];
    assign hub_en_o         = store_q[4][6:5];
    assign irqclk_en_o      = store_q[4][3];
    assign cpu_en_o         = store_q[4][1:0];

    // R9: writes at read-only or absent indices leave storage untouched
    a_r9_ro_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i >= PTR_W'(NSTORE)) |=> (store_q == $past(store_q)));

    // R7: latched straps never move after capture
    a_r7_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done_q && $past(cap_done_q)) |-> ($stable(fs_q) && $stable(apic_q)));

    // R4: the effective code moves only on a register write
    a_r4_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done_q && $past(cap_done_q) && !$past(wr_en_i)) |-> $stable(freq_code_o));

endmodule

// File: rtl/clkgen_i2c_regfile.sv
module clkgen_i2c_regfile
    import clkgen_regs_pkg::*;
#(
    parameter logic [6:0] ADDR        = 7'h69,
    parameter int         PTR_W       = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pdn_i,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_low_o,
    input  logic [4:0]  strap_fs_i,
    input  logic        strap_apic_i,
    output logic [5:0]  freq_code_o,
    output logic        tristate_o,
    output logic        spread_en_o,
    output logic        spread_quarter_o,
    output logic [2:0]  aux_en_o,
    output logic [7:0]  sdram_en_o,
    output logic [7:0]  pci_en_o,
    output logic [1:0]  hub_en_o,
    output logic        irqclk_en_o,
    output logic [1:0]  cpu_en_o
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [PTR_W-1:0]  wr_idx, rd_idx;
    logic [BYTE_W-1:0] wr_data, rd_data;

    cgr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    cgr_bus_engine #(.ADDR(ADDR), .PTR_W(PTR_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .pdn_i      (pdn_i),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .sda_low_o  (sda_low_o),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data),
        .rd_idx_o   (rd_idx),
        .rd_data_i  (rd_data)
    );

    cgr_reg_bank #(.PTR_W(PTR_W)) u_bank (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en_i          (wr_en),
        .wr_idx_i         (wr_idx),
        .wr_data_i        (wr_data),
        .rd_idx_i         (rd_idx),
        .rd_data_o        (rd_data),
        .strap_fs_i       (strap_fs_i),
        .strap_apic_i     (strap_apic_i),
        .freq_code_o      (freq_code_o),
        .tristate_o       (tristate_o),
        .spread_en_o      (spread_en_o),
        .spread_quarter_o (spread_quarter_o),
        .aux_en_o         (aux_en_o),
        .sdram_en_o       (sdram_en_o),
        .pci_en_o         (pci_en_o),
        .hub_en_o         (hub_en_o),
        .irqclk_en_o      (irqclk_en_o),
        .cpu_en_o         (cpu_en_o)
    );

endmodule

// File: tb/clkgen_i2c_regfile_tb.sv
module clkgen_i2c_regfile_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam int         HALF       = 8;
    localparam logic [6:0] DUT_ADDR   = 7'h69;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdn_i = 1'b0;
    logic tb_scl = 1'b1;
    logic tb_sda_low = 1'b0;
    logic sda_bus;
    logic sda_low_o;
    logic [4:0] strap_fs_i = 5'b10110;
    logic strap_apic_i = 1'b1;
    logic [5:0] freq_code_o;
    logic tristate_o, spread_en_o, spread_quarter_o, irqclk_en_o;
    logic [2:0] aux_en_o;
    logic [7:0] sdram_en_o, pci_en_o;
    logic [1:0] hub_en_o, cpu_en_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = ~(tb_sda_low | sda_low_o);

    clkgen_i2c_regfile #(.ADDR(DUT_ADDR)) dut_i (
        .clk(clk), .rst_n(rst_n), .pdn_i(pdn_i),
        .scl_i(tb_scl), .sda_i(sda_bus), .sda_low_o(sda_low_o),
        .strap_fs_i(strap_fs_i), .strap_apic_i(strap_apic_i),
        .freq_code_o(freq_code_o), .tristate_o(tristate_o),
        .spread_en_o(spread_en_o), .spread_quarter_o(spread_quarter_o),
        .aux_en_o(aux_en_o), .sdram_en_o(sdram_en_o), .pci_en_o(pci_en_o),
        .hub_en_o(hub_en_o), .irqclk_en_o(irqclk_en_o), .cpu_en_o(cpu_en_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        tb_sda_low = 1'b0; hp();
        tb_scl = 1'b1;     hp();
        tb_sda_low = 1'b1; hp();
        tb_scl = 1'b0;     hp();
    endtask

    task automatic bus_stop();
        tb_sda_low = 1'b1; hp();
        tb_scl = 1'b1;     hp();
        tb_sda_low = 1'b0; hp();
        hp();
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            tb_sda_low = ~v[i];
            hp();
            tb_scl = 1'b1;
            hp();
            tb_scl = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        send_bits(v, 8);
        tb_sda_low = 1'b0;
        hp();
        tb_scl = 1'b1;
        repeat (HALF/2) @(negedge clk);
        acked = !sda_bus;
        repeat (HALF/2) @(negedge clk);
        tb_scl = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] v);
        tb_sda_low = 1'b0;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            hp();
            tb_scl = 1'b1;
            repeat (HALF/2) @(negedge clk);
            v = {v[6:0], sda_bus};
            repeat (HALF/2) @(negedge clk);
            tb_scl = 1'b0;
            repeat (2) @(negedge clk);
        end
        tb_sda_low = ack;
        hp();
        tb_scl = 1'b1;
        hp();
        tb_scl = 1'b0;
        repeat (2) @(negedge clk);
        tb_sda_low = 1'b0;
    endtask

    // Full write: address, two placeholders, then n data bytes
    task automatic write_seq(input logic [7:0] d [0:9], input int n, input string tag);
        logic a;
        bus_start();
        send_byte({DUT_ADDR, 1'b0}, a); check({tag, " R1 address ack"}, a, 1);
        send_byte(8'hFF, a);            check({tag, " R2 command ack"}, a, 1);
        send_byte(8'hFF, a);            check({tag, " R2 count ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a);
            check({tag, " R3 data ack"}, a, 1);
        end
        bus_stop();
        check({tag, " R13 line released"}, sda_low_o, 0);
    endtask

    task automatic read_seq(input int n, output logic [7:0] q [0:11]);
        logic a;
        bus_start();
        send_byte({DUT_ADDR, 1'b1}, a);
        check("R1 read address ack", a, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, q[i]);
        bus_stop();
        check("R13 line released after read", sda_low_o, 0);
    endtask

    task automatic t_reset();
        check("R8 sdram default", sdram_en_o, 8'hFF);
        check("R8 pci default", pci_en_o, 8'hFF);
        check("R8 aux default", aux_en_o, 3'b111);
        check("R8 spread amount default", spread_quarter_o, 1);
        check("R8 spread off default", spread_en_o, 0);
        check("R8 hub/irq/cpu default", {hub_en_o, irqclk_en_o, cpu_en_o}, 5'b11111);
        check("R5 tristate default", tristate_o, 0);
        check("R4 strap code", freq_code_o, 6'h16);
        check("R13 idle line", sda_low_o, 0);
    endtask

    task automatic t_read_defaults();
        logic [7:0] q [0:11];
        logic [7:0] ex [0:10] = '{8'h00, 8'h00, 8'h00, 8'h3E, 8'hFF, 8'hFF,
                                  8'hFF, 8'h90, 8'h98, 8'h21, 8'h00};
        read_seq(11, q);
        for (int i = 0; i < 11; i++)
            check($sformatf("R10 R8 R7 R9 read byte %0d", i), q[i], ex[i]);
    endtask

    task automatic t_bad_address();
        logic a;
        bus_start();
        send_byte({DUT_ADDR ^ 7'h01, 1'b0}, a); check("R1 mismatch no ack", a, 0);
        send_byte(8'h01, a);                    check("R1 no ack until START", a, 0);
        bus_stop();
        check("R1 mismatch wrote nothing", tristate_o, 0);
    endtask

    task automatic t_write_fields();
        logic [7:0] d [0:9] = '{8'h5E, 8'h07, 8'hA5, 8'h3C, 8'h00, 0, 0, 0, 0, 0};
        logic [7:0] q [0:11];
        write_seq(d, 5, "fields");
        check("R4 software code", freq_code_o, 6'h35);
        check("R2 placeholders not stored", tristate_o, 0);
        check("R6 spread enable", spread_en_o, 1);
        check("R6 spread quarter", spread_quarter_o, 1);
        check("R6 aux enables", aux_en_o, 3'b001);
        check("R3 R6 sdram mask", sdram_en_o, 8'hA5);
        check("R3 R6 pci mask", pci_en_o, 8'h3C);
        check("R6 reg4 enables", {hub_en_o, irqclk_en_o, cpu_en_o}, 5'b00000);
        read_seq(7, q);
        check("R7 reg1 echo with writes", q[3], 8'h27);
        check("R7 reg4 echo unwritable", q[6], 8'h94);
    endtask

    task automatic t_tristate_hw();
        logic [7:0] d [0:9] = '{8'h01, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        write_seq(d, 1, "tristate");
        check("R5 tristate set", tristate_o, 1);
        check("R4 hardware code", freq_code_o, 6'h16);
    endtask

    task automatic t_ro_and_straps();
        logic [7:0] d [0:9] = '{8'h00, 8'h1E, 8'hFF, 8'hFF, 8'hFF, 8'h11,
                               8'h00, 8'h00, 8'h55, 8'h00};
        logic [7:0] q [0:11];
        write_seq(d, 9, "readonly");
        strap_fs_i = 5'b01001;
        strap_apic_i = 1'b0;
        repeat (20) @(negedge clk);
        check("R7 code ignores later straps", freq_code_o, 6'h16);
        read_seq(11, q);
        check("R7 reg1 echo held", q[3], 8'h3E);
        check("R7 reg4 echo held", q[6], 8'hFF);
        check("R9 reg5 written", q[7], 8'h11);
        check("R9 id high fixed", q[8], 8'h98);
        check("R9 id low fixed", q[9], 8'h21);
        check("R9 beyond range zero", q[10], 8'h00);
        check("R5 tristate cleared", tristate_o, 0);
    endtask

    task automatic t_abort();
        logic a;
        logic [7:0] q [0:11];
        bus_start();
        send_byte({DUT_ADDR, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h01, a);
        check("R11 first data ack", a, 1);
        send_bits(8'hF0, 4);
        bus_start();
        send_byte({DUT_ADDR, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h08, a);
        bus_stop();
        check("R11 restart writes index 0", freq_code_o, 6'h00);
        check("R11 tristate rewritten", tristate_o, 0);
        check("R11 index 1 untouched", aux_en_o, 3'b111);
        read_seq(4, q);
        check("R11 reg1 readback", q[3], 8'h3E);
    endtask

    task automatic t_pdn();
        logic a;
        logic [7:0] q [0:11];
        pdn_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_start();
        send_byte({DUT_ADDR, 1'b0}, a);
        check("R12 no ack in power-down", a, 0);
        send_byte(8'hFF, a);
        bus_stop();
        check("R12 line released", sda_low_o, 0);
        pdn_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R12 outputs kept", sdram_en_o, 8'hFF);
        read_seq(3, q);
        check("R12 reg0 kept", q[2], 8'h08);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_read_defaults();
        t_bad_address();
        t_write_fields();
        t_tristate_hw();
        t_ro_and_straps();
        t_abort();
        t_pdn();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule